// File: doc/BRIEF.md
# Receive Header Start-Delimiter Search and Check

This block sits behind the receive demodulator and turns a stream of hard-decided header symbols into a framed payload. Once acquisition reports lock, it hunts for a programmed 16-bit start delimiter. An optional timer counts received symbols and gives up on the search when the delimiter does not show up in time. After the delimiter, it parses the header fields that the selected protocol mode carries, checks the header CRC, and then raises a data-ready envelope over the payload.

The mode-3 signal field can switch the payload modulation to DQPSK on the fly. A length field can end the packet after a set number of symbols. A policy bit decides whether a CRC mismatch drops the link. Each time the block gives up a packet, it sends a one-cycle request to re-enter acquisition. The received signal, service, length and CRC fields are held in status outputs for the rest of the receiver.

Top module: `hdr_rx_sync`

## Requirements
- R1: After reset, every status output is zero, and `data_rdy_o`, `pay_qpsk_o` and `rtn_acq_o` are low.
- R2: A pulse on `acq_done_i` while idle starts a search. The delimiter is found on the accepted symbol (with `bit_vld_i` high) at which the last 16 accepted symbols equal `cfg_sfd_i` taken MSB first. At least 16 symbols must have been accepted since the search started.
- R3: When `cfg_tmo_en_i` is high and the delimiter has not been found, the T-th accepted symbol of the search (T = `cfg_tmo_i`, 8 bits) ends the search with an acquisition request. If the delimiter completes on that same symbol, the delimiter wins. When the timer is disabled, the search never times out.
- R4: The header fields follow the delimiter, each sent MSB first. Mode 0 (`cfg_mode_i`=0) has no fields. Mode 1 has a 16-bit CRC. Mode 2 has a 16-bit length, then the CRC. Mode 3 has an 8-bit signal field, an 8-bit service field, the length, then the CRC.
- R5: The expected CRC is CCITT CRC-16 (polynomial x^16+x^12+x^5+1, register preset to 0xFFFF, MSB-first shift, result inverted). It is computed over the header fields between the delimiter and the CRC field. In mode 1 no bits are covered, so the expected value is 0x0000.
- R6: On a CRC mismatch, `cfg_crc_drop_i`=1 returns the block to acquisition without raising data-ready. With `cfg_crc_drop_i`=0 the error is ignored and the payload follows.
- R7: `pay_qpsk_o` is set when data-ready rises. In mode 3 it is 1 exactly when the received signal field equals 0x14. In mode 0 it is 0. In modes 1 and 2 it equals `cfg_qpsk_i`.
- R8: The status outputs take a field's value on the cycle after the field's last symbol is accepted. They are changed by nothing else, so a field absent from the current mode keeps its old value.
- R9: `data_rdy_o` rises on the cycle after the last header symbol is accepted, or after the delimiter in mode 0. In modes 2 and 3 with `cfg_len_stop_i`=1, it falls after the L-th accepted payload symbol, where L is the received length. With L=0 it never rises.
- R10: `abort_i` ends a search, a header or a payload at the next edge and returns the block to acquisition. This is the only way a payload ends when length stop is not active.
- R11: `rtn_acq_o` is a single-cycle pulse on each return to idle (timeout, CRC drop, length end, abort). `acq_done_i` outside idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_done_i | input | 1 | Acquisition lock strobe, starts a search |
| abort_i | input | 1 | External end of packet |
| bit_i | input | 1 | Demodulated symbol |
| bit_vld_i | input | 1 | Symbol strobe |
| cfg_mode_i | input | 2 | Protocol mode 0..3 |
| cfg_sfd_i | input | 16 | Start delimiter to match |
| cfg_tmo_i | input | 8 | Search timeout in symbols |
| cfg_tmo_en_i | input | 1 | Search timer enable |
| cfg_crc_drop_i | input | 1 | Drop link on CRC mismatch |
| cfg_len_stop_i | input | 1 | End payload by length field |
| cfg_qpsk_i | input | 1 | Programmed payload modulation (1 = DQPSK) |
| stat_sig_o | output | 8 | Received signal field |
| stat_svc_o | output | 8 | Received service field |
| stat_len_o | output | 16 | Received length field |
| stat_crc_o | output | 16 | Received CRC field |
| data_rdy_o | output | 1 | Payload envelope |
| pay_qpsk_o | output | 1 | Payload is DQPSK |
| rtn_acq_o | output | 1 | Return-to-acquisition pulse |

## Verification
Every result is registered exactly once. The delimiter decision, a field capture, the CRC verdict, a length end and an abort therefore each show up one clock after the edge that accepts the deciding symbol or samples the abort. The bench drives each symbol at a falling edge and samples at the next falling edge, so each check lands in the first cycle the result is due. It samples once more a cycle later to confirm that the acquisition request has dropped. Timeout checks sample both the symbol before the limit, where nothing may happen, and the limit symbol itself.

// File: rtl/hdr_rx_pkg.sv
package hdr_rx_pkg;

    localparam int SFD_W   = 16;
    localparam int TMO_W   = 8;
    localparam int SIG_W   = 8;
    localparam int LEN_W   = 16;
    localparam int CRC_W   = 16;
    localparam int POS_W   = 6;

    // virtual header positions, aligned so that every mode ends at CRC_END
    localparam int SIG_END = SIG_W - 1;
    localparam int SVC_END = 2 * SIG_W - 1;
    localparam int LEN_END = 2 * SIG_W + LEN_W - 1;
    localparam int CRC_END = 2 * SIG_W + LEN_W + CRC_W - 1;
    localparam int PROT_N  = 2 * SIG_W + LEN_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_HDR,
        ST_DATA
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [POS_W-1:0]   vpos;
        logic [CRC_W-1:0]   fsh;
        logic [SIG_W-1:0]   sig;
        logic [SIG_W-1:0]   svc;
        logic [LEN_W-1:0]   len;
        logic [CRC_W-1:0]   rcrc;
        logic [LEN_W-1:0]   pcnt;
        logic               rdy;
        logic               qpsk;
        logic               rtn;
    } rx_regs_t;

    function automatic logic [POS_W-1:0] hdr_start(input logic [1:0] mode);
        case (mode)
            2'd1:    hdr_start = POS_W'(CRC_END + 1 - CRC_W);
            2'd2:    hdr_start = POS_W'(CRC_END + 1 - CRC_W - LEN_W);
            default: hdr_start = '0;
        endcase
    endfunction

endpackage

// File: rtl/hdr_crc16.sv
module hdr_crc16 #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i) begin
            crc_d = '1;
        end else if (shift_i) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ ((crc_q[W-1] ^ bit_i) ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/hdr_sfd_match.sv
module hdr_sfd_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic [W-1:0] sfd_i,
    output logic         hit_o
);
    localparam int FW = $clog2(W);

    logic [W-2:0]  sreg_d, sreg_q;
    logic [FW-1:0] fill_d, fill_q;

    always_comb begin
        sreg_d = sreg_q;
        fill_d = fill_q;
        if (clr_i) begin
            sreg_d = '0;
            fill_d = '0;
        end else if (shift_i) begin
            sreg_d = {sreg_q[W-3:0], bit_i};
            if (fill_q != FW'(W - 1)) fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            fill_q <= '0;
        end else begin
            sreg_q <= sreg_d;
            fill_q <= fill_d;
        end
    end

    assign hit_o = (fill_q == FW'(W - 1)) && ({sreg_q, bit_i} == sfd_i);
endmodule

// File: rtl/hdr_sfd_timer.sv
module hdr_sfd_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW:0]   nxt;

    assign nxt      = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
    assign expire_o = en_i && (nxt >= {1'b0, limit_i});

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                   cnt_d = '0;
        else if (tick_i && !nxt[TW]) cnt_d = nxt[TW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hdr_rx_sync.sv
module hdr_rx_sync
    import hdr_rx_pkg::*;
#(
    parameter logic [SIG_W-1:0] SIG_QPSK = 8'h14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_done_i,
    input  logic             abort_i,
    input  logic             bit_i,
    input  logic             bit_vld_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [SFD_W-1:0] cfg_sfd_i,
    input  logic [TMO_W-1:0] cfg_tmo_i,
    input  logic             cfg_tmo_en_i,
    input  logic             cfg_crc_drop_i,
    input  logic             cfg_len_stop_i,
    input  logic             cfg_qpsk_i,
    output logic [SIG_W-1:0] stat_sig_o,
    output logic [SIG_W-1:0] stat_svc_o,
    output logic [LEN_W-1:0] stat_len_o,
    output logic [CRC_W-1:0] stat_crc_o,
    output logic             data_rdy_o,
    output logic             pay_qpsk_o,
    output logic             rtn_acq_o
);
    rx_regs_t d, q;

    logic             srch_clr, srch_shift, sfd_hit, tmo_hit;
    logic             crc_init, crc_shift;
    logic [CRC_W-1:0] crc_run;
    logic [CRC_W-1:0] nb;
    logic             len_stop_act;

    hdr_sfd_match #(.W(SFD_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (srch_clr),
        .shift_i (srch_shift),
        .bit_i   (bit_i),
        .sfd_i   (cfg_sfd_i),
        .hit_o   (sfd_hit)
    );

    hdr_sfd_timer #(.TW(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (srch_clr),
        .tick_i   (srch_shift),
        .en_i     (cfg_tmo_en_i),
        .limit_i  (cfg_tmo_i),
        .expire_o (tmo_hit)
    );

    hdr_crc16 #(.W(CRC_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (crc_init),
        .shift_i (crc_shift),
        .bit_i   (bit_i),
        .crc_o   (crc_run)
    );

    assign nb           = {q.fsh[CRC_W-2:0], bit_i};
    assign len_stop_act = cfg_len_stop_i && cfg_mode_i[1];

    always_comb begin
        d          = q;
        srch_clr   = 1'b0;
        srch_shift = 1'b0;
        crc_init   = 1'b0;
        crc_shift  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (acq_done_i) begin
                    d.st     = ST_SEARCH;
                    srch_clr = 1'b1;
                end
            end
            ST_SEARCH: begin
                if (abort_i) begin
                    d.st = ST_IDLE;
                end else if (bit_vld_i) begin
                    srch_shift = 1'b1;
                    if (sfd_hit) begin
                        if (cfg_mode_i == 2'd0) begin
                            d.st   = ST_DATA;
                            d.pcnt = '0;
                            d.qpsk = 1'b0;
                        end else begin
                            d.st     = ST_HDR;
                            d.vpos   = hdr_start(cfg_mode_i);
                            crc_init = 1'b1;
                        end
                    end else if (tmo_hit) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_HDR: begin
                if (abort_i) begin
                    d.st = ST_IDLE;
                end else if (bit_vld_i) begin
                    d.fsh     = nb;
                    d.vpos    = q.vpos + 1'b1;
                    crc_shift = (q.vpos < POS_W'(PROT_N));
                    if (q.vpos == POS_W'(SIG_END)) d.sig = nb[SIG_W-1:0];
                    if (q.vpos == POS_W'(SVC_END)) d.svc = nb[SIG_W-1:0];
                    if (q.vpos == POS_W'(LEN_END)) d.len = nb[LEN_W-1:0];
                    if (q.vpos == POS_W'(CRC_END)) begin
                        d.rcrc = nb;
                        if ((nb != ~crc_run) && cfg_crc_drop_i) begin
                            d.st = ST_IDLE;
                        end else if (len_stop_act && (q.len == '0)) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_DATA;
                            d.pcnt = '0;
                            d.qpsk = (cfg_mode_i == 2'd3) ? (q.sig == SIG_QPSK) : cfg_qpsk_i;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (abort_i) begin
                    d.st = ST_IDLE;
                end else if (bit_vld_i) begin
                    d.pcnt = q.pcnt + 1'b1;
                    if (len_stop_act && ((q.pcnt + 1'b1) == q.len)) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.rdy = (d.st == ST_DATA);
        d.rtn = (d.st == ST_IDLE) && (q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign stat_sig_o = q.sig;
    assign stat_svc_o = q.svc;
    assign stat_len_o = q.len;
    assign stat_crc_o = q.rcrc;
    assign data_rdy_o = q.rdy;
    assign pay_qpsk_o = q.qpsk;
    assign rtn_acq_o  = q.rtn;
endmodule

// File: rtl/hdr_rx_sync_chk.sv
module hdr_rx_sync_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bit_vld_i,
    input logic        abort_i,
    input logic [1:0]  cfg_mode_i,
    input logic [7:0]  stat_sig_o,
    input logic [15:0] stat_len_o,
    input logic        data_rdy_o,
    input logic        pay_qpsk_o,
    input logic        rtn_acq_o
);
    AST_RTN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rtn_acq_o |=> !rtn_acq_o); // R11

    AST_RTN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rtn_acq_o |-> !data_rdy_o); // R11

    AST_ABORT_ENDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && data_rdy_o) |=> (rtn_acq_o && !data_rdy_o)); // R10

    AST_READY_ON_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy_o) |-> $past(bit_vld_i)); // R9

    AST_MODE0_BPSK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy_o && cfg_mode_i == 2'd0 && $stable(cfg_mode_i)) |-> !pay_qpsk_o); // R7

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> $stable(stat_len_o)); // R8

    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> $stable(stat_sig_o)); // R8
endmodule

bind hdr_rx_sync hdr_rx_sync_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld_i  (bit_vld_i),
    .abort_i    (abort_i),
    .cfg_mode_i (cfg_mode_i),
    .stat_sig_o (stat_sig_o),
    .stat_len_o (stat_len_o),
    .data_rdy_o (data_rdy_o),
    .pay_qpsk_o (pay_qpsk_o),
    .rtn_acq_o  (rtn_acq_o)
);

// File: tb/hdr_rx_sync_tb.sv
module hdr_rx_sync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SFD = 16'hF3A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_done_i = 1'b0, abort_i = 1'b0, bit_i = 1'b0, bit_vld_i = 1'b0;
    logic [1:0]  cfg_mode_i = 2'd0;
    logic [15:0] cfg_sfd_i = SFD;
    logic [7:0]  cfg_tmo_i = 8'd200;
    logic        cfg_tmo_en_i = 1'b1, cfg_crc_drop_i = 1'b1, cfg_len_stop_i = 1'b0, cfg_qpsk_i = 1'b0;
    logic [7:0]  stat_sig_o, stat_svc_o;
    logic [15:0] stat_len_o, stat_crc_o;
    logic        data_rdy_o, pay_qpsk_o, rtn_acq_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdr_rx_sync dut_i (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        bit_i = b; bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) tick_bit(w[i]);
    endtask

    task automatic start_search();
        acq_done_i = 1'b1;
        @(negedge clk);
        acq_done_i = 1'b0;
    endtask

    task automatic do_abort();
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [15:0] hdr_crc(input logic [1:0] m, input logic [7:0] s,
                                            input logic [7:0] v, input logic [15:0] l);
        logic [15:0] c = 16'hFFFF;
        if (m == 2'd3) begin
            for (int i = 7; i >= 0; i--) c = crc_step(c, s[i]);
            for (int i = 7; i >= 0; i--) c = crc_step(c, v[i]);
        end
        if (m >= 2'd2) for (int i = 15; i >= 0; i--) c = crc_step(c, l[i]);
        return ~c;
    endfunction

    task automatic send_hdr(input logic [1:0] m, input logic [7:0] s, input logic [7:0] v,
                            input logic [15:0] l, input logic [15:0] c);
        if (m == 2'd3) begin
            send_word({8'h00, s}, 8);
            send_word({8'h00, v}, 8);
        end
        if (m >= 2'd2) send_word(l, 16);
        if (m >= 2'd1) send_word(c, 16);
    endtask

    task automatic lead_in(input int ones);
        start_search();
        for (int i = 0; i < ones; i++) tick_bit(1'b1);
        send_word(SFD, 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_len, last_crc, ccrc, l;
        logic [7:0]  s, v;
        logic        expq;
        int          seen;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "status", {stat_sig_o, stat_svc_o, stat_len_o}, 32'h0);
        chk("R1", "crc", {16'h0, stat_crc_o}, 32'h0);
        chk("R1", "flags", {data_rdy_o, pay_qpsk_o, rtn_acq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after release", {data_rdy_o, pay_qpsk_o, rtn_acq_o}, 32'h0);

        // main sweep over mode, programmed modulation and signal field
        last_len = 16'h0; last_crc = 16'h0;
        for (int m = 0; m < 4; m++) begin
            for (int qp = 0; qp < 2; qp++) begin
                for (int k = 0; k < 3; k++) begin
                    s = (k == 0) ? 8'h14 : ((k == 1) ? 8'h0A : 8'h55);
                    v = s ^ 8'h3C ^ 8'(m);
                    l = {s, 6'(m * 8 + qp), 2'(k)};
                    cfg_mode_i = 2'(m); cfg_qpsk_i = qp[0];
                    ccrc = hdr_crc(2'(m), s, v, l);
                    lead_in(20);
                    send_hdr(2'(m), s, v, l, ccrc);
                    chk("R2", "data_rdy after header", {31'h0, data_rdy_o}, 32'h1);
                    chk("R5", "no return on good crc", {31'h0, rtn_acq_o}, 32'h0);
                    expq = (m == 0) ? 1'b0 : ((m == 3) ? (s == 8'h14) : qp[0]);
                    chk("R7", "payload modulation", {31'h0, pay_qpsk_o}, {31'h0, expq});
                    if (m == 3) begin
                        chk("R8", "signal", {24'h0, stat_sig_o}, {24'h0, s});
                        chk("R4", "service", {24'h0, stat_svc_o}, {24'h0, v});
                    end
                    if (m >= 2) last_len = l;
                    if (m >= 1) last_crc = ccrc;
                    chk("R8", "length", {16'h0, stat_len_o}, {16'h0, last_len});
                    chk("R4", "crc field", {16'h0, stat_crc_o}, {16'h0, last_crc});
                    for (int p = 0; p < 4; p++) tick_bit(p[0]);
                    chk("R10", "payload held without length stop", {31'h0, data_rdy_o}, 32'h1);
                    abort_i = 1'b1;
                    @(negedge clk);
                    abort_i = 1'b0;
                    chk("R10", "abort returns", {30'h0, data_rdy_o, rtn_acq_o}, 32'h1);
                    @(negedge clk);
                    chk("R11", "pulse one cycle", {31'h0, rtn_acq_o}, 32'h0);
                end
            end
        end

        // search timeout sweep
        cfg_mode_i = 2'd0;
        for (int t = 0; t < 5; t++) begin
            int lim;
            lim = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 16 : (t == 3) ? 40 : 255;
            cfg_tmo_i = 8'(lim);
            start_search();
            seen = 0;
            for (int i = 0; i < lim - 1; i++) begin
                tick_bit(1'b1);
                if (rtn_acq_o) seen++;
            end
            chk("R3", "no timeout before limit", 32'(seen), 32'h0);
            tick_bit(1'b1);
            chk("R3", "timeout at limit", {31'h0, rtn_acq_o}, 32'h1);
            @(negedge clk);
            chk("R11", "timeout pulse one cycle", {31'h0, rtn_acq_o}, 32'h0);
        end

        // delimiter completing on the limit symbol wins
        cfg_tmo_i = 8'd24;
        lead_in(8);
        chk("R3", "sfd on limit wins", {30'h0, data_rdy_o, rtn_acq_o}, 32'h2);
        do_abort();

        // timer disabled
        cfg_tmo_en_i = 1'b0; cfg_tmo_i = 8'd10;
        start_search();
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            tick_bit(1'b1);
            if (rtn_acq_o) seen++;
        end
        chk("R3", "no timeout when disabled", 32'(seen), 32'h0);
        send_word(SFD, 16);
        chk("R2", "sfd after long search", {31'h0, data_rdy_o}, 32'h1);
        // acquisition strobe during payload is ignored
        start_search();
        chk("R11", "acq_done ignored in payload", {30'h0, data_rdy_o, rtn_acq_o}, 32'h2);
        do_abort();
        cfg_tmo_en_i = 1'b1; cfg_tmo_i = 8'd200;

        // CRC mismatch policy
        for (int m = 1; m < 4; m++) begin
            for (int dr = 0; dr < 2; dr++) begin
                cfg_mode_i = 2'(m); cfg_crc_drop_i = dr[0];
                ccrc = hdr_crc(2'(m), 8'h0A, 8'h21, 16'h0033) ^ 16'h0001;
                lead_in(5);
                send_hdr(2'(m), 8'h0A, 8'h21, 16'h0033, ccrc);
                chk("R6", "data_rdy on bad crc", {31'h0, data_rdy_o}, {31'h0, ~dr[0]});
                chk("R6", "return on bad crc", {31'h0, rtn_acq_o}, {31'h0, dr[0]});
                chk("R8", "bad crc latched", {16'h0, stat_crc_o}, {16'h0, ccrc});
                if (data_rdy_o) do_abort(); else @(negedge clk);
            end
        end
        chk("R5", "mode 1 expects zero", {16'h0, hdr_crc(2'd1, 8'h0, 8'h0, 16'h0)}, 32'h0);
        cfg_crc_drop_i = 1'b1;

        // length stop
        cfg_len_stop_i = 1'b1;
        for (int m = 2; m < 4; m++) begin
            for (int n = 0; n < 6; n++) begin
                cfg_mode_i = 2'(m);
                l = 16'(n);
                lead_in(3);
                send_hdr(2'(m), 8'h14, 8'h01, l, hdr_crc(2'(m), 8'h14, 8'h01, l));
                if (n == 0) begin
                    chk("R9", "zero length never ready", {30'h0, data_rdy_o, rtn_acq_o}, 32'h1);
                    @(negedge clk);
                end else begin
                    for (int p = 0; p < n - 1; p++) tick_bit(1'b0);
                    chk("R9", "ready before last symbol", {30'h0, data_rdy_o, rtn_acq_o}, 32'h2);
                    tick_bit(1'b1);
                    chk("R9", "end after last symbol", {30'h0, data_rdy_o, rtn_acq_o}, 32'h1);
                    @(negedge clk);
                end
            end
        end
        // length stop has no effect in mode 1
        cfg_mode_i = 2'd1;
        lead_in(3);
        send_hdr(2'd1, 8'h0, 8'h0, 16'h0, 16'h0000);
        for (int p = 0; p < 10; p++) tick_bit(1'b0);
        chk("R9", "mode 1 ignores length stop", {30'h0, data_rdy_o, rtn_acq_o}, 32'h2);
        do_abort();
        cfg_len_stop_i = 1'b0;

        // abort during header
        cfg_mode_i = 2'd3;
        lead_in(3);
        send_word(16'h00AB, 8);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk("R10", "abort in header", {30'h0, data_rdy_o, rtn_acq_o}, 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule